// File: doc/BRIEF.md
# Variable-Frequency Phase-Accumulator Oscillator

This block is a numerically controlled oscillator clocked by a reference clock. Software loads a 16-bit frequency word one byte at a time, through an upper-byte strobe and a lower-byte strobe that share one data bus. On every reference cycle with the run input high, a 16-bit phase register adds an increment derived from that word. The top bit of the phase register is the square-wave output.

The output frequency is the increment divided by 65536, times the reference clock frequency. The increment is the word itself when the word is below 0x8000. For a word at or above 0x8000, the increment is the word's 16-bit two's complement.

A one-cycle pulse marks each rising edge of the square wave, so a downstream fixed-frequency stage can use it as a clock enable. Power-of-two words from 1 to 0x8000 give an exact half-high, half-low wave.

Top module: `vf_nco`

## Requirements
- R1: While reset is held, and before any word is written, sq_out and rise_tick are 0. The stored word resets to 0.
- R2: A cycle with hi_we high loads byte_in into word bits 15:8. A cycle with lo_we high loads byte_in into bits 7:0. A byte whose strobe is low keeps its value, and with both strobes high both bytes take byte_in.
- R3: A written word first affects the phase on the clock edge after the edge that stored it.
- R4: The increment is the word when the word is below 0x8000, and (65536 − word) mod 65536 otherwise. This makes 0x8000 an increment of 0x8000, which toggles sq_out every cycle.
- R5: On each clock edge with run_en high, the phase becomes (phase + increment) mod 65536. sq_out is bit 15 of the phase.
- R6: On a clock edge with run_en low, the phase clears to 0. sq_out is then low and no tick occurs.
- R7: rise_tick is high in exactly those cycles where sq_out is high and was low in the previous cycle. It never stays high for two cycles in a row.
- R8: A power-of-two word gives sq_out high for exactly half of each output period, with one tick per period.
- R9: A word of 0 keeps sq_out low indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en | input | 1 | Run enable; low clears the phase |
| hi_we | input | 1 | Load strobe for word bits 15:8 |
| lo_we | input | 1 | Load strobe for word bits 7:0 |
| byte_in | input | 8 | Byte data for either half of the word |
| sq_out | output | 1 | Variable-frequency square wave |
| rise_tick | output | 1 | One-cycle pulse on each rising edge of sq_out |

## Verification
The hardest case to reach from the ports is the folded increment region, where a word at or above 0x8000 must run at the same rate as its two's-complement partner. The 0x8000 word is the extreme point of that region. The stimulus loads 0xFF00 and 0x0100 from the same cleared phase and counts ticks over 1024 cycles, and both runs must give the same count. It then loads 0x8000 and checks that sq_out toggles every cycle. Byte-wise writes that change only one half of a running word are compared cycle by cycle against a behavioural phase model.

// File: rtl/vf_nco_pkg.sv
package vf_nco_pkg;
  localparam int unsigned LANE_W_DEF = 8;
  localparam int unsigned LANES = 2;
endpackage

// File: rtl/vf_word_reg.sv
module vf_word_reg #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2,
  localparam int unsigned WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_we,
  input  logic [LANE_W-1:0] lane_d,
  output logic [WORD_W-1:0] word_q
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_next;
    logic [LANE_W-1:0] lane_q;

    always_comb begin
      lane_next = lane_q;
      if (lane_we[g]) lane_next = lane_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_next;
    end

    assign word_q[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/vf_step_fold.sv
module vf_step_fold #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] word,
  output logic [W-1:0] step
);
  // Upper half of the word range folds back to its two's complement.
  always_comb begin
    if (word[W-1]) step = (~word) + {{(W-1){1'b0}}, 1'b1};
    else           step = word;
  end
endmodule

// File: rtl/vf_phase_acc.sv
module vf_phase_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_en,
  input  logic [W-1:0] step,
  output logic [W-1:0] phase_q
);
  logic [W-1:0] phase_next;

  always_comb begin
    if (run_en) phase_next = phase_q + step;
    else        phase_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_next;
  end
endmodule

// File: rtl/vf_edge_tick.sv
module vf_edge_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic tick
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign tick = level & ~level_q;
endmodule

// File: rtl/vf_nco.sv
module vf_nco #(
  parameter int unsigned LANE_W = vf_nco_pkg::LANE_W_DEF,
  localparam int unsigned ACC_W = LANE_W * vf_nco_pkg::LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [LANE_W-1:0] byte_in,
  output logic              sq_out,
  output logic              rise_tick
);
  logic [1:0]       rst_sync;
  logic             rst_n_s;
  logic [ACC_W-1:0] word_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] phase_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  vf_word_reg #(.LANE_W(LANE_W), .LANES(vf_nco_pkg::LANES)) u_word (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .lane_we ({hi_we, lo_we}),
    .lane_d  (byte_in),
    .word_q  (word_q)
  );

  vf_step_fold #(.W(ACC_W)) u_fold (
    .word (word_q),
    .step (step)
  );

  vf_phase_acc #(.W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .run_en  (run_en),
    .step    (step),
    .phase_q (phase_q)
  );

  assign sq_out = phase_q[ACC_W-1];

  vf_edge_tick u_tick (
    .clk   (clk),
    .rst_n (rst_n_s),
    .level (sq_out),
    .tick  (rise_tick)
  );
endmodule

// File: rtl/vf_nco_chk.sv
module vf_nco_chk #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned ACC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              hi_we,
  input logic [LANE_W-1:0] byte_in,
  input logic [ACC_W-1:0]  word_q,
  input logic              sq_out,
  input logic              rise_tick
);
  localparam logic [ACC_W-1:0] HALF = {1'b1, {(ACC_W-1){1'b0}}};

  AST_WORD_HI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |=> word_q[ACC_W-1:LANE_W] == $past(byte_in)); // R2
  AST_WORD_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_we |=> word_q[ACC_W-1:LANE_W] == $past(word_q[ACC_W-1:LANE_W])); // R2
  AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && word_q == HALF) |=> sq_out != $past(sq_out)); // R4
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !sq_out); // R6
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !rise_tick); // R6
  AST_TICK_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |-> sq_out); // R7
  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_tick |=> !rise_tick); // R7
  AST_ZERO_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (word_q == '0 && !sq_out) |=> !sq_out); // R9
endmodule

bind vf_nco vf_nco_chk #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .run_en    (run_en),
  .hi_we     (hi_we),
  .byte_in   (byte_in),
  .word_q    (word_q),
  .sq_out    (sq_out),
  .rise_tick (rise_tick)
);

// File: tb/tb_vf_nco.sv
module tb_vf_nco;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       run_en;
  logic       hi_we;
  logic       lo_we;
  logic [7:0] byte_in;
  logic       sq_out;
  logic       rise_tick;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural reference state.
  int m_word = 0;
  int m_phase = 0;
  int m_prev_hi = 0;

  vf_nco dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .hi_we(hi_we),
    .lo_we(lo_we), .byte_in(byte_in), .sq_out(sq_out), .rise_tick(rise_tick)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int step_of(int w);
    if (w < 32768) return w;
    return (65536 - w) % 65536;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word = 0; m_phase = 0; m_prev_hi = 0;
    end else begin
      m_prev_hi = m_phase / 32768;
      if (run_en) m_phase = (m_phase + step_of(m_word)) % 65536;
      else        m_phase = 0;
      if (hi_we) m_word = (m_word % 256) + 256 * int'(byte_in);
      if (lo_we) m_word = (m_word / 256) * 256 + int'(byte_in);
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // R3 R5 R7: per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 sq_out", int'(sq_out), m_phase / 32768);
      check("R7 rise_tick", int'(rise_tick),
            ((m_phase / 32768) == 1 && m_prev_hi == 0) ? 1 : 0);
    end
  end

  task automatic put(bit h, bit l, logic [7:0] d);
    @(negedge clk);
    hi_we = h; lo_we = l; byte_in = d;
    @(negedge clk);
    hi_we = 0; lo_we = 0; byte_in = 8'h00;
  endtask

  task automatic measure(int n, output int highs, output int ticks);
    highs = 0; ticks = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      highs += int'(sq_out);
      ticks += int'(rise_tick);
    end
  endtask

  task automatic restart();
    @(negedge clk); run_en = 0;
    @(negedge clk); run_en = 1;
  endtask

  initial begin
    int h;
    int t;
    rst_n = 0; run_en = 0; hi_we = 0; lo_we = 0; byte_in = 0;
    repeat (3) @(negedge clk);
    check("R1 sq_out in reset", int'(sq_out), 0);
    check("R1 tick in reset", int'(rise_tick), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 R9: reset word is zero, output stays low while running
    run_en = 1;
    measure(50, h, t);
    check("R9 zero word highs", h, 0);
    check("R9 zero word ticks", t, 0);
    // R8: power-of-two word 0x1000 gives half duty
    put(1, 0, 8'h10);
    restart();
    measure(64, h, t);
    check("R8 0x1000 highs", h, 32);
    check("R8 0x1000 ticks", t, 4);
    // R2 R4: word 0x0100 versus folded 0xFF00
    put(1, 0, 8'h01);
    restart();
    measure(1024, h, t);
    check("R4 0x0100 ticks", t, 4);
    put(1, 0, 8'hFF);
    restart();
    measure(1024, h, t);
    check("R4 0xFF00 ticks", t, 4);
    check("R8 0xFF00 highs", h, 512);
    // R4: 0x8000 toggles each cycle
    put(1, 0, 8'h80);
    restart();
    measure(20, h, t);
    check("R4 0x8000 highs", h, 10);
    check("R4 0x8000 ticks", t, 10);
    // R2 R3: change low byte only while running, then both strobes at once
    put(1, 0, 8'h03);
    put(0, 1, 8'h45);
    measure(300, h, t);
    put(1, 1, 8'h02);
    measure(300, h, t);
    put(0, 1, 8'hF7);
    measure(200, h, t);
    // R6: dropping run clears output and ticks
    @(negedge clk); run_en = 0;
    measure(20, h, t);
    check("R6 idle highs", h, 0);
    check("R6 idle ticks", t, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule